// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the data half of a small processor. Seven 8-bit general registers sit beside an external input port. A 14-bit control word is presented every clock. It names two operand sources, one destination, and one of a handful of ALU functions. The two operand selectors each pick a register or the external input. The ALU combines the two operands, and the result appears on the output bus in the same cycle. On the next rising edge the result is loaded into the named destination register, if there is one.

A sequencer elsewhere in the chip drives the control word. Register-to-register micro-operations such as a subtract into a third register, self-clearing by XOR, or a plain move to the output take one cycle each. Code zero in a source field means "take the external input". Code zero in the destination field means "write nothing", so a result can be shown on the output bus without disturbing any register.

Top module: `cw_datapath`

## Requirements
- R1: The control word is split into fields by bit position: bits 13:11 select operand A, bits 10:8 select operand B, bits 7:5 select the destination, and bits 4:0 hold the ALU opcode.
- R2: An operand select of 3'b000 puts `ext_in` on that operand. Codes 3'b001 to 3'b111 put the register with that number on it.
- R3: A destination code of 3'b000 changes no register. Codes 3'b001 to 3'b111 load that register with the ALU result on the rising clock edge, and every other register keeps its value.
- R4: Arithmetic opcodes work modulo 256: 5'b00000 yields A, 5'b00001 yields A+1, 5'b00010 yields A+B, 5'b00101 yields A-B, and 5'b00110 yields A-1.
- R5: Logic opcodes work bitwise: 5'b01000 yields A AND B, 5'b01010 yields A OR B, 5'b01100 yields A XOR B, and 5'b01110 yields NOT A.
- R6: Opcode 5'b10000 shifts A right by one bit and 5'b11000 shifts A left by one bit. The vacated bit is filled with 0.
- R7: Any opcode not listed in R4 to R6 yields A unchanged.
- R8: `out_bus` shows the ALU result combinationally in the same cycle as the control word, whatever the destination code is.
- R9: While the synchronous, active-high `rst` is high at a rising edge, every register is cleared to 0.
- R10: Control word 010_011_001_00101 leaves R1 equal to R2 minus R3. Control word 101_101_101_01100 clears R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Control word holding operand selects, destination and opcode |
| ext_in | input | 8 | External data that can serve as an operand |
| out_bus | output | 8 | ALU result, combinational |

## Verification
The ALU result is due on `out_bus` in the same cycle as the control word. The bench therefore drives each word just after a falling edge and samples a few nanoseconds later, well before the next rising edge. A register write becomes visible one rising edge later. The bench updates its own register model after that edge and reads registers back with a transfer opcode and a zero destination in a later cycle. Reset is checked the same way: the registers are read back one cycle after the edge on which `rst` was high.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int OP_W     = 5;
    localparam int NUM_REGS = (1 << SEL_W) - 1;
    localparam int CW_W     = 3 * SEL_W + OP_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [OP_W-1:0]   opc_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    typedef enum opc_t {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    // Field order, most significant first: A select, B select, destination, opcode
    typedef struct packed {
        sel_t src_a;
        sel_t src_b;
        sel_t dst;
        opc_t op;
    } ctrl_t;

    function automatic word_t alu_eval(opc_t op, word_t a, word_t b);
        word_t r;
        case (op)
            OP_INC:  r = a + word_t'(1);
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_DEC:  r = a - word_t'(1);
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_NOT:  r = ~a;
            OP_SHR:  r = {1'b0, a[DATA_W-1:1]};
            OP_SHL:  r = {a[DATA_W-2:0], 1'b0};
            default: r = a;   // transfer and every unlisted code
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cwd_regbank.sv
module cwd_regbank
    import cwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sel_t  wr_sel,
    input  word_t wr_data,
    output bank_t regs
);

    logic [NUM_REGS-1:0] wr_hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign wr_hit[i] = (wr_sel == sel_t'(i + 1));

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_hit[i])
                regs[i] <= wr_data;
        end

        // R3: the addressed register takes the ALU result
        p_load_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_sel == sel_t'(i + 1)) |=> (regs[i] == $past(wr_data)));

        // R3: registers not addressed hold their value
        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_sel != sel_t'(i + 1)) |=> $stable(regs[i]));

        // R9: reset clears every register
        p_clear_r9: assert property (@(posedge clk)
            rst |=> (regs[i] == '0));
    end

endmodule

// File: rtl/cwd_operand_sel.sv
module cwd_operand_sel
    import cwd_pkg::*;
(
    input  sel_t  sel,
    input  word_t ext_in,
    input  bank_t regs,
    output word_t opnd
);

    always_comb begin
        if (sel == '0)
            opnd = ext_in;
        else
            opnd = regs[sel - sel_t'(1)];
    end

endmodule

// File: rtl/cwd_alu.sv
module cwd_alu
    import cwd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opc_t  op,
    input  word_t a,
    input  word_t b,
    output word_t y
);

    assign y = alu_eval(op, a, b);

    // R10: an operand XORed with itself gives zero
    p_xor_self_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_XOR && a == b) |-> (y == '0));

    // R5: complement differs from A in every bit
    p_not_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOT) |-> ((y ^ a) == '1));

    // R6: zero fill on both shifts
    p_shr_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHR) |-> (y[DATA_W-1] == 1'b0));
    p_shl_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHL) |-> (y[0] == 1'b0));

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] ext_in,
    output logic [DATA_W-1:0] out_bus
);

    ctrl_t cw;
    bank_t regs;
    sel_t  src_sel [2];
    word_t opnd    [2];
    word_t result;

    assign cw         = ctrl_t'(ctrl_word);
    assign src_sel[0] = cw.src_a;
    assign src_sel[1] = cw.src_b;

    for (genvar p = 0; p < 2; p++) begin : g_port
        cwd_operand_sel u_sel (
            .sel    (src_sel[p]),
            .ext_in (ext_in),
            .regs   (regs),
            .opnd   (opnd[p])
        );
    end

    cwd_alu u_alu (
        .clk (clk),
        .rst (rst),
        .op  (cw.op),
        .a   (opnd[0]),
        .b   (opnd[1]),
        .y   (result)
    );

    cwd_regbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (cw.dst),
        .wr_data (result),
        .regs    (regs)
    );

    assign out_bus = result;

    // R8: a zero destination leaves every register as it was, while the bus still shows the result
    p_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
        (cw.dst == '0) |=> (regs == $past(regs)));

    // R2: an external-input transfer shows the input on the bus
    p_ext_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (cw.src_a == '0 && cw.op == OP_PASS) |-> (out_bus == ext_in));

endmodule

// File: tb/test_cw_datapath.sv
module test_cw_datapath;
    import cwd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ctrl_word = '0;
    logic [7:0]  ext_in = '0;
    logic [7:0]  out_bus;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [8];

    always #10 clk = ~clk;   // 50 MHz

    cw_datapath i_cw_datapath (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .ext_in    (ext_in),
        .out_bus   (out_bus)
    );

    function automatic logic [13:0] mk(logic [2:0] a, logic [2:0] b, logic [2:0] d, logic [4:0] op);
        return {a, b, d, op};
    endfunction

    function automatic logic [7:0] ref_alu(logic [4:0] op, logic [7:0] a, logic [7:0] b);
        case (op)
            5'b00001: return 8'((a + 1) % 256);
            5'b00010: return 8'((a + b) % 256);
            5'b00101: return 8'((256 + a - b) % 256);
            5'b00110: return 8'((255 + a) % 256);
            5'b01000: return a & b;
            5'b01010: return a | b;
            5'b01100: return a ^ b;
            5'b01110: return 8'(255 - a);
            5'b10000: return a / 2;
            5'b11000: return 8'((a * 2) % 256);
            default:  return a;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] op);
        case (op)
            5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R4";
            5'b01000, 5'b01010, 5'b01100, 5'b01110:          return "R5";
            5'b10000, 5'b11000:                               return "R6";
            default:                                          return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one control word, check the bus in the same cycle (R8), update the model after the edge
    task automatic step(logic [13:0] cw, logic [7:0] ext, string req);
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] exp;
        @(negedge clk);
        ctrl_word = cw;
        ext_in    = ext;
        #3;
        a   = (cw[13:11] == 3'd0) ? ext : model[cw[13:11]];
        b   = (cw[10:8]  == 3'd0) ? ext : model[cw[10:8]];
        exp = ref_alu(cw[4:0], a, b);
        check(req, out_bus, exp);
        @(posedge clk);
        #1;
        if (cw[7:5] != 3'd0) model[cw[7:5]] = exp;
    endtask

    task automatic load(logic [2:0] r, logic [7:0] v);
        step(mk(3'd0, 3'd0, r, 5'b00000), v, "R2");
    endtask

    task automatic read_reg(logic [2:0] r, string req);
        step(mk(r, 3'd0, 3'd0, 5'b00000), 8'h00, req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: all registers read zero after reset
        for (int r = 1; r < 8; r++) read_reg(3'(r), "R9");

        // R10: subtract into R1, XOR self-clear of R5
        load(3'd2, 8'h5A);
        load(3'd3, 8'h1C);
        step(mk(3'd2, 3'd3, 3'd1, 5'b00101), 8'h00, "R10");
        read_reg(3'd1, "R10");
        check("R10", out_bus, 8'h3E);
        load(3'd5, 8'hA7);
        step(mk(3'd5, 3'd5, 3'd5, 5'b01100), 8'h00, "R10");
        read_reg(3'd5, "R10");
        check("R10", out_bus, 8'h00);

        // R4 wrap corners
        load(3'd4, 8'hFF);
        step(mk(3'd4, 3'd0, 3'd4, 5'b00001), 8'h00, "R4");
        read_reg(3'd4, "R4");
        step(mk(3'd4, 3'd0, 3'd6, 5'b00110), 8'h00, "R4");
        read_reg(3'd6, "R4");
        step(mk(3'd6, 3'd0, 3'd7, 5'b00010), 8'h01, "R4");

        // R6 shifts with both end bits set
        load(3'd7, 8'h81);
        step(mk(3'd7, 3'd0, 3'd0, 5'b10000), 8'h00, "R6");
        step(mk(3'd7, 3'd0, 3'd0, 5'b11000), 8'h00, "R6");

        // R7 unlisted codes
        step(mk(3'd7, 3'd2, 3'd0, 5'b00011), 8'h33, "R7");
        step(mk(3'd2, 3'd7, 3'd0, 5'b11111), 8'h33, "R7");

        // R3/R8: zero destination shows result but keeps registers
        step(mk(3'd2, 3'd3, 3'd0, 5'b00010), 8'h00, "R8");
        for (int r = 1; r < 8; r++) read_reg(3'(r), "R3");

        // R1/R2: external input on B only, fields at their positions
        step(mk(3'd3, 3'd0, 3'd2, 5'b01010), 8'hC0, "R1");
        read_reg(3'd2, "R1");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0] ops [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                                     5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
            logic [4:0] op;
            op = ($urandom % 8 == 0) ? 5'($urandom) : ops[$urandom % 11];
            step(mk(3'($urandom), 3'($urandom), 3'($urandom), op), 8'($urandom), tag_of(op));
        end
        for (int r = 1; r < 8; r++) read_reg(3'(r), "R3");

        // R9: reset in the middle of a run, with a write pending
        @(negedge clk);
        ctrl_word = mk(3'd0, 3'd0, 3'd1, 5'b00000);
        ext_in    = 8'h77;
        rst       = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        for (int r = 1; r < 8; r++) read_reg(3'(r), "R9");

        summary();
        $finish;
    end

endmodule